// File: doc/BRIEF.md
# Elastic Bit-Buffer Jitter Smoother

This block removes timing wobble from a serial bit stream. Bits arrive with an uneven strobe and are written into a one-bit-wide circular buffer. A phase accumulator inside the block produces its own strobe at even spacing, and that strobe reads the bits back out. A slow digital loop steers the accumulator by comparing the buffer fill to its midpoint. The accumulator's carry sets the average output rate. Because the loop is slow, wobble in the input strobe does not reach the output strobe.

A four-bit configuration word controls the block. It chooses whether the smoother sits in the transmit lane or the receive lane, or is taken out of both. It also sets the buffer length and the loop corner. A fixed-mode pin overrides the length and corner choices with a short buffer and the slow corner. When the buffer comes close to empty or full, the loop switches to a much wider bandwidth so that no bit is dropped or read twice. It returns to its normal gain once the fill is back near the midpoint.

Top module: `jitterSmoother`

## Requirements
- R1: Bits 1:0 of the configuration word place the smoother: 00 in the transmit lane and 01 in the receive lane. With 10 or 11 it is out of both lanes, and each lane's data and strobe outputs follow that lane's inputs combinationally.
- R2: The lane that does not hold the smoother passes its data and strobe straight through combinationally.
- R3: In the selected lane, each output strobe is a one-cycle pulse carrying one bit. After reset the output bit sequence is half-buffer-length zeros followed by the input bits in order, with no bit lost or repeated.
- R4: Bit 3 of the configuration word sets the buffer length: 0 gives 64 bits (32 leading zeros after reset) and 1 gives 32 bits (16 leading zeros).
- R5: Bit 2 sets the loop corner. 0 selects the slow corner, where the correction is the fill error scaled by 2^8 and shifted right by 8. 1 selects the faster corner, where the same product is shifted right by 4. Both keep data intact under bounded strobe wobble.
- R6: When the fixed-mode input is high, the buffer is 32 bits and the slow corner is used, whatever bits 3:2 say.
- R7: When the fill comes within 4 bits of empty or full, the shift drops to 1. It returns to normal once the fill error is within one eighth of the buffer length. An input running about 1.6 % fast at the slow corner therefore causes no error.
- R8: The error output goes high when a write meets a full buffer or a read meets an empty one. It stays high until reset and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWord | input | 4 | Placement [1:0], corner [2], length [3] |
| fixedMode | input | 1 | Forces 32-bit buffer and slow corner |
| txDataIn | input | 1 | Transmit lane data in |
| txStrobeIn | input | 1 | Transmit lane bit strobe in |
| rxDataIn | input | 1 | Receive lane data in |
| rxStrobeIn | input | 1 | Receive lane bit strobe in |
| txDataOut | output | 1 | Transmit lane data out |
| txStrobeOut | output | 1 | Transmit lane bit strobe out |
| rxDataOut | output | 1 | Receive lane data out |
| rxStrobeOut | output | 1 | Receive lane bit strobe out |
| slipErr | output | 1 | Sticky buffer overflow/underflow flag |

## Verification
The bench runs every placement, both lengths, both corners and fixed mode. In each run it drives wobbling strobes and compares the output against a queue that it pre-loads with the expected number of leading zeros. A wrong centring point or a wrong length decode therefore shows up as shifted data. It also drives a stream that runs slightly fast at the slow corner. A design whose guard mode never engages would overflow there and raise the error flag. It then forces overflow and underflow on purpose and checks that the flag latches. A flag that clears itself, or that never sets, is reported.

// File: rtl/jaPkg.sv
package jaPkg;
  // strobes from the loop control to the bit store
  typedef struct packed {
    logic wr;        // store the incoming bit
    logic rd;        // emit one bit
    logic fwd;       // emit the bit being written (store empty)
    logic recenter;  // reload pointers at half length
    logic deep;      // long buffer selected
  } bufCtl_t;

  localparam logic [1:0] LOC_TX = 2'b00;
  localparam logic [1:0] LOC_RX = 2'b01;
endpackage

// File: rtl/jaCtrl.sv
module jaCtrl
  import jaPkg::*;
#(
  parameter int DEPTH_MAX = 64,
  parameter int ACC_W     = 16,
  parameter int NOM_INC   = 8192,
  parameter int GAIN_SH   = 8,
  parameter int SH_LOW    = 8,
  parameter int SH_HIGH   = 4,
  parameter int SH_GUARD  = 1,
  parameter int MARGIN    = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] loc,
  input  logic      deep,
  input  logic      lowCorner,
  input  logic      inStrobe,
  output bufCtl_t   ctl,
  output logic      errFlag
);
  localparam int FILL_W = $clog2(DEPTH_MAX) + 1;
  localparam int ERR_W  = FILL_W + 1;
  localparam int INC_W  = ACC_W + 2;

  logic [FILL_W-1:0] depth, half, fill;
  logic [2:0]        keyQ;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W:0]    accSum;
  logic              wide, active, recenter;
  logic              wrReq, rdReq, ovf, unf, nearEdge, inWindow;
  logic signed [ERR_W-1:0] fillErr;
  logic [ERR_W-1:0]  absErr;
  logic [3:0]        shamt;
  logic signed [INC_W-1:0] errWide, corr, inc;

  always_comb begin
    depth    = deep ? FILL_W'(DEPTH_MAX) : FILL_W'(DEPTH_MAX / 2);
    half     = depth >> 1;
    active   = ~loc[1];
    recenter = ({deep, loc} != keyQ);
    fillErr  = $signed({1'b0, fill}) - $signed({1'b0, half});
    absErr   = fillErr[ERR_W-1] ? $unsigned(-fillErr) : $unsigned(fillErr);
    nearEdge = (fill <= FILL_W'(MARGIN)) || (fill >= depth - FILL_W'(MARGIN));
    inWindow = absErr < ERR_W'(depth >> 3);
    shamt    = wide ? 4'(SH_GUARD) : (lowCorner ? 4'(SH_LOW) : 4'(SH_HIGH));
    errWide  = INC_W'(fillErr);
    corr     = (errWide <<< GAIN_SH) >>> shamt;
    inc      = INC_W'(NOM_INC) + corr;
    accSum   = {1'b0, acc} + inc[ACC_W:0];
    rdReq    = accSum[ACC_W] & active & ~recenter;
    wrReq    = inStrobe & active & ~recenter;
    ovf      = wrReq & ~rdReq & (fill == depth);
    unf      = rdReq & ~wrReq & (fill == '0);
    ctl.wr       = wrReq & ~ovf;
    ctl.rd       = rdReq & ~unf;
    ctl.fwd      = ctl.wr & ctl.rd & (fill == '0);
    ctl.recenter = recenter;
    ctl.deep     = deep;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || recenter) begin
      keyQ <= {deep, loc};
      fill <= half;
      acc  <= '0;
      wide <= 1'b0;
      if (!rst_n) errFlag <= 1'b0;
    end else begin
      acc  <= accSum[ACC_W-1:0];
      fill <= fill + FILL_W'(ctl.wr) - FILL_W'(ctl.rd);
      if (nearEdge)      wide <= 1'b1;
      else if (inWindow) wide <= 1'b0;
      errFlag <= errFlag | ovf | unf;
    end
  end

  a_r8_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= depth);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |=> errFlag);
  a_r3_recentre_half: assert property (@(posedge clk) disable iff (!rst_n)
    recenter |=> (fill == $past(half)));
  a_r7_rate_positive: assert property (@(posedge clk) disable iff (!rst_n)
    inc > 0);
endmodule

// File: rtl/jaBuffer.sv
module jaBuffer
  import jaPkg::*;
#(
  parameter int DEPTH_MAX = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  bufCtl_t ctl,
  input  logic    inBit,
  output logic    outBit,
  output logic    outStrobe
);
  localparam int PTR_W = $clog2(DEPTH_MAX);

  logic [DEPTH_MAX-1:0] store;
  logic [PTR_W-1:0]     wPtr, rPtr, mask, halfPtr;

  always_comb begin
    mask    = ctl.deep ? PTR_W'(DEPTH_MAX - 1) : PTR_W'(DEPTH_MAX / 2 - 1);
    halfPtr = ctl.deep ? PTR_W'(DEPTH_MAX / 2) : PTR_W'(DEPTH_MAX / 4);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctl.recenter) begin
      store     <= '0;
      wPtr      <= halfPtr;
      rPtr      <= '0;
      outBit    <= 1'b0;
      outStrobe <= 1'b0;
    end else begin
      outStrobe <= ctl.rd;
      if (ctl.wr) begin
        store[wPtr] <= inBit;
        wPtr        <= (wPtr + 1'b1) & mask;
      end
      if (ctl.rd) begin
        outBit <= ctl.fwd ? inBit : store[rPtr];
        rPtr   <= (rPtr + 1'b1) & mask;
      end
    end
  end

  a_r3_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.rd && !ctl.recenter) |=> outStrobe);
endmodule

// File: rtl/jitterSmoother.sv
module jitterSmoother
  import jaPkg::*;
#(
  parameter int DEPTH_MAX = 64,
  parameter int ACC_W     = 16,
  parameter int NOM_INC   = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] cfgWord,
  input  logic       fixedMode,
  input  logic       txDataIn,
  input  logic       txStrobeIn,
  input  logic       rxDataIn,
  input  logic       rxStrobeIn,
  output logic       txDataOut,
  output logic       txStrobeOut,
  output logic       rxDataOut,
  output logic       rxStrobeOut,
  output logic       slipErr
);
  bufCtl_t ctl;
  logic deep, lowCorner, onTx, onRx, inBit, inStrobe, bufBit, bufStrobe;

  always_comb begin
    deep      = ~fixedMode & ~cfgWord[3];
    lowCorner = fixedMode | ~cfgWord[2];
    onTx      = (cfgWord[1:0] == LOC_TX);
    onRx      = (cfgWord[1:0] == LOC_RX);
    inBit     = onRx ? rxDataIn   : txDataIn;
    inStrobe  = onRx ? rxStrobeIn : txStrobeIn;
    txDataOut   = onTx ? bufBit    : txDataIn;
    txStrobeOut = onTx ? bufStrobe : txStrobeIn;
    rxDataOut   = onRx ? bufBit    : rxDataIn;
    rxStrobeOut = onRx ? bufStrobe : rxStrobeIn;
  end

  jaCtrl #(.DEPTH_MAX(DEPTH_MAX), .ACC_W(ACC_W), .NOM_INC(NOM_INC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .loc(cfgWord[1:0]), .deep(deep),
    .lowCorner(lowCorner), .inStrobe(inStrobe), .ctl(ctl), .errFlag(slipErr)
  );

  jaBuffer #(.DEPTH_MAX(DEPTH_MAX)) u_buf (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .inBit(inBit),
    .outBit(bufBit), .outStrobe(bufStrobe)
  );

  a_r1_bypass_through: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWord[1] |-> (txDataOut == txDataIn && rxDataOut == rxDataIn &&
                    txStrobeOut == txStrobeIn && rxStrobeOut == rxStrobeIn));
endmodule

// File: tb/jitterSmoother_bench.sv
module jitterSmoother_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] cfgWord;
  logic fixedMode;
  logic txDataIn, txStrobeIn, rxDataIn, rxStrobeIn;
  logic txDataOut, txStrobeOut, rxDataOut, rxStrobeOut, slipErr;

  int checks = 0;
  int fails  = 0;
  bit expQ[$];
  logic [15:0] lfsr = 16'hACE1;
  bit stopMon;
  int badBits, passBad, recv;

  always #5 clk = ~clk;

  jitterSmoother u_jitterSmoother (
    .clk(clk), .rst_n(rst_n), .cfgWord(cfgWord), .fixedMode(fixedMode),
    .txDataIn(txDataIn), .txStrobeIn(txStrobeIn), .rxDataIn(rxDataIn),
    .rxStrobeIn(rxStrobeIn), .txDataOut(txDataOut), .txStrobeOut(txStrobeOut),
    .rxDataOut(rxDataOut), .rxStrobeOut(rxStrobeOut), .slipErr(slipErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit nextBit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic doReset(input logic [3:0] cfg, input logic fix);
    int half;
    rst_n = 1'b0; cfgWord = cfg; fixedMode = fix;
    txDataIn = 0; txStrobeIn = 0; rxDataIn = 0; rxStrobeIn = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    half = (fix || cfg[3]) ? 16 : 32;
    expQ.delete();
    for (int i = 0; i < half; i++) expQ.push_back(1'b0);
  endtask

  task automatic runStream(input logic [3:0] cfg, input logic fix, input int nBits,
                           input bit fast, input string req);
    int gapNom[8]  = '{8, 5, 11, 6, 10, 8, 3, 13};
    int gapFast[8] = '{8, 5, 11, 6, 10, 8, 3, 12};
    bit onRx = (cfg[1:0] == 2'b01);
    int depth = (fix || cfg[3]) ? 32 : 64;
    doReset(cfg, fix);
    stopMon = 0; badBits = 0; passBad = 0; recv = 0;
    fork
      begin
        for (int i = 0; i < nBits; i++) begin
          int gap = fast ? gapFast[i % 8] : gapNom[i % 8];
          for (int c = 0; c < gap; c++) begin
            @(posedge clk); #1;
            if (c == gap - 1) begin
              bit b = nextBit();
              if (onRx) begin rxStrobeIn = 1; rxDataIn = b; txStrobeIn = nextBit(); txDataIn = nextBit(); end
              else begin txStrobeIn = 1; txDataIn = b; rxStrobeIn = nextBit(); rxDataIn = nextBit(); end
              expQ.push_back(b);
            end else begin
              if (onRx) begin rxStrobeIn = 0; txStrobeIn = nextBit(); txDataIn = nextBit(); end
              else begin txStrobeIn = 0; rxStrobeIn = nextBit(); rxDataIn = nextBit(); end
            end
          end
        end
        @(posedge clk); #1;
        txStrobeIn = 0; rxStrobeIn = 0;
        stopMon = 1;
      end
      begin
        while (!stopMon) begin
          @(negedge clk);
          if (onRx ? rxStrobeOut : txStrobeOut) begin
            recv++;
            if (expQ.size() == 0) badBits++;
            else if ((onRx ? rxDataOut : txDataOut) !== expQ.pop_front()) badBits++;
          end
          if (onRx ? (txDataOut !== txDataIn || txStrobeOut !== txStrobeIn)
                   : (rxDataOut !== rxDataIn || rxStrobeOut !== rxStrobeIn)) passBad++;
        end
      end
    join
    check(badBits == 0, {req, " R3 bit order and leading zeros"}, badBits, 0);
    check(recv > nBits - depth, {req, " R3 output keeps pace"}, recv, nBits - depth);
    check(passBad == 0, {req, " R2 other lane passes through"}, passBad, 0);
    check(slipErr == 1'b0, {req, " R8 no slip under bounded wobble"}, slipErr, 0);
  endtask

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // reset state
    doReset(4'b0000, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check(txStrobeOut == 0 && rxStrobeOut == 0, "R3 strobes low in reset", txStrobeOut, 0);
    check(slipErr == 0, "R8 flag low in reset", slipErr, 0);

    runStream(4'b0000, 1'b0, 400, 1'b0, "R1 tx long slow R4");
    runStream(4'b0001, 1'b0, 400, 1'b0, "R1 rx long slow");
    runStream(4'b1000, 1'b0, 400, 1'b0, "R4 tx short");
    runStream(4'b1101, 1'b0, 400, 1'b0, "R5 rx short fast corner");
    runStream(4'b0100, 1'b1, 400, 1'b0, "R6 fixed mode");
    runStream(4'b1000, 1'b0, 3000, 1'b1, "R7 fast input slow corner");
    runStream(4'b0100, 1'b0, 1000, 1'b1, "R5 fast input fast corner");

    // R1 out of both lanes: combinational pass-through
    for (int loc = 2; loc < 4; loc++) begin
      int mis = 0;
      doReset({2'b00, 2'(loc)}, 1'b0);
      for (int v = 0; v < 16; v++) begin
        {txDataIn, txStrobeIn, rxDataIn, rxStrobeIn} = 4'(v);
        #1;
        if (txDataOut !== txDataIn || txStrobeOut !== txStrobeIn ||
            rxDataOut !== rxDataIn || rxStrobeOut !== rxStrobeIn) mis++;
        @(posedge clk); #1;
      end
      check(mis == 0, "R1 bypass lanes follow inputs", mis, 0);
      check(slipErr == 0, "R8 no flag in bypass", slipErr, 0);
    end

    // R8 overflow
    doReset(4'b1000, 1'b0);
    txStrobeIn = 1;
    repeat (100) @(posedge clk);
    #1 txStrobeIn = 0;
    @(negedge clk);
    check(slipErr == 1, "R8 overflow sets flag", slipErr, 1);
    repeat (50) @(posedge clk);
    @(negedge clk);
    check(slipErr == 1, "R8 flag sticky", slipErr, 1);
    doReset(4'b1000, 1'b0);
    @(negedge clk);
    check(slipErr == 0, "R8 reset clears flag", slipErr, 0);
    // R8 underflow: no input
    repeat (2000) @(posedge clk);
    @(negedge clk);
    check(slipErr == 1, "R8 underflow sets flag", slipErr, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule